// File: doc/BRIEF.md
# Two-Event Join Controller

This controller watches two single-cycle event strobes, `ev_a` and `ev_b`. They may arrive in either order or in the same cycle. When both have been observed it raises a single-cycle `fire` strobe. It then parks in a halted state and ignores any further events on either strobe.

A restart strobe, `abort_r`, cancels whatever round is in progress, including a halted one, and arms a fresh wait for both events. The round then repeats without end. A restart always wins: a restart that lands in the same cycle as the completing event still suppresses the emission. Two sticky status outputs show which of the two events have been seen in the current round.

All outputs are registered. Events sampled on a clock edge are reflected on the outputs right after that edge. A synchronous active-high reset puts the controller into the armed waiting state.

Top module: `rendezvous_join`

## Requirements
- R1: After reset, `fire`, `seen_a` and `seen_b` are all 0, and the controller waits for both events.
- R2: While waiting, an `ev_a` pulse sampled on a clock edge makes `seen_a` read 1 after that edge, and an `ev_b` pulse does the same for `seen_b` (1 means the event has been observed since the last restart).
- R3: When the second of the two events is sampled, in either order, `fire` is 1 for exactly the one cycle following that edge.
- R4: When `ev_a` and `ev_b` are sampled on the same edge while waiting and neither was seen before, `fire` is 1 in the cycle following that edge.
- R5: After `fire`, the controller is halted. Further `ev_a` or `ev_b` pulses produce no `fire`, and both seen flags stay at 1.
- R6: An `abort_r` pulse clears both seen flags and restarts the wait, from a partial round or from the halted state. A later pair of events fires again.
- R7: If `abort_r` is sampled on the same edge as the completing event, `fire` stays 0 and both seen flags read 0 after that edge.
- R8: A repeat of an event already seen in the current round has no effect: no `fire`, and both flags keep their values.
- R9: `fire` is never 1 unless both seen flags read 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_a | input | 1 | First event strobe |
| ev_b | input | 1 | Second event strobe |
| abort_r | input | 1 | Restart strobe, highest priority |
| fire | output | 1 | Single-cycle join strobe |
| seen_a | output | 1 | First event observed this round |
| seen_b | output | 1 | Second event observed this round |

## Verification
A flag that fails to latch or fails to clear shows on `seen_a` or `seen_b` in the cycle right after the offending edge. A wrong control state shows as a missing, repeated or extra `fire` in the cycle after the next event. Because of this, each directed scenario compares all three outputs after every single edge. The restart cases cover the halted state and the same-edge collision with a completing event, since a wrong priority there shows only as one stray `fire`.

// File: rtl/rendezvous_join_pkg.sv
package rendezvous_join_pkg;
  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_HALT = 1'b1
  } rdv_state_e;
endpackage

// File: rtl/rdv_seen_flag.sv
// One sticky flag per watched event.
module rdv_seen_flag (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic arm,
  input  logic ev,
  output logic q,
  output logic nxt
);
  assign nxt = q | (arm & ev);

  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else            q <= nxt;
  end
endmodule

// File: rtl/rdv_ctrl.sv
// Join state machine: waits until every flag is set, fires once, then halts.
module rdv_ctrl
  import rendezvous_join_pkg::*;
#(
  parameter int N_EV = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            abort_r,
  input  logic [N_EV-1:0] seen_nxt,
  output logic            arm,
  output logic            fire
);
  rdv_state_e state;

  assign arm = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst || abort_r) begin
      state <= ST_WAIT;
      fire  <= 1'b0;
    end else if (state == ST_WAIT && (&seen_nxt)) begin
      state <= ST_HALT;
      fire  <= 1'b1;
    end else begin
      fire  <= 1'b0;
    end
  end
endmodule

// File: rtl/rendezvous_join.sv
module rendezvous_join (
  input  logic clk,
  input  logic rst,
  input  logic ev_a,
  input  logic ev_b,
  input  logic abort_r,
  output logic fire,
  output logic seen_a,
  output logic seen_b
);
  localparam int N_EV = 2;

  logic [N_EV-1:0] ev_vec;
  logic [N_EV-1:0] seen_q;
  logic [N_EV-1:0] seen_nxt;
  logic            arm;

  assign ev_vec = {ev_b, ev_a};

  for (genvar i = 0; i < N_EV; i++) begin : g_flag
    rdv_seen_flag u_flag (
      .clk (clk),
      .rst (rst),
      .clr (abort_r),
      .arm (arm),
      .ev  (ev_vec[i]),
      .q   (seen_q[i]),
      .nxt (seen_nxt[i])
    );
  end

  rdv_ctrl #(.N_EV(N_EV)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .abort_r  (abort_r),
    .seen_nxt (seen_nxt),
    .arm      (arm),
    .fire     (fire)
  );

  assign seen_a = seen_q[0];
  assign seen_b = seen_q[1];
endmodule

// File: rtl/rendezvous_join_chk.sv
module rendezvous_join_chk (
  input logic clk,
  input logic rst,
  input logic ev_a,
  input logic ev_b,
  input logic abort_r,
  input logic fire,
  input logic seen_a,
  input logic seen_b
);
  // Tracks whether this round has already fired.
  logic fired_round;
  always_ff @(posedge clk) begin
    if (rst || abort_r) fired_round <= 1'b0;
    else if (fire)      fired_round <= 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!fire && !seen_a && !seen_b));

  a_r2_a_latches: assert property (@(posedge clk) disable iff (rst)
    (ev_a && !abort_r) |=> seen_a);

  a_r2_b_latches: assert property (@(posedge clk) disable iff (rst)
    (ev_b && !abort_r) |=> seen_b);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

  a_r5_no_refire: assert property (@(posedge clk) disable iff (rst)
    fired_round |-> !fire);

  a_r6_abort_clears: assert property (@(posedge clk) disable iff (rst)
    abort_r |=> (!fire && !seen_a && !seen_b));

  a_r8_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    (seen_a && seen_b && !abort_r) |=> (seen_a && seen_b));

  a_r9_fire_needs_both: assert property (@(posedge clk) disable iff (rst)
    fire |-> (seen_a && seen_b));
endmodule

bind rendezvous_join rendezvous_join_chk u_chk (.*);

// File: tb/rendezvous_join_bench.sv
module rendezvous_join_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst, ev_a, ev_b, abort_r;
  logic fire, seen_a, seen_b;
  int   checks = 0;
  int   errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rendezvous_join u_rendezvous_join (
    .clk(clk), .rst(rst), .ev_a(ev_a), .ev_b(ev_b), .abort_r(abort_r),
    .fire(fire), .seen_a(seen_a), .seen_b(seen_b)
  );

  // One clock edge with the given strobes; returns at the following negedge.
  task automatic drive(input logic a, input logic b, input logic r);
    ev_a = a; ev_b = b; abort_r = r;
    @(negedge clk);
    ev_a = 1'b0; ev_b = 1'b0; abort_r = 1'b0;
  endtask

  // Compares {fire, seen_a, seen_b}.
  task automatic chk(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {fire, seen_a, seen_b};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {fire,seen_a,seen_b} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; ev_a = 1'b0; ev_b = 1'b0; abort_r = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset state", 3'b000);
  endtask

  task automatic t_a_then_b();
    do_reset();
    drive(1, 0, 0); chk("R2 a seen", 3'b010);
    drive(0, 0, 0); chk("R2 a held", 3'b010);
    drive(0, 1, 0); chk("R3 fire a then b", 3'b111);
    drive(0, 0, 0); chk("R3 fire one cycle", 3'b011);
  endtask

  task automatic t_b_then_a();
    do_reset();
    drive(0, 1, 0); chk("R2 b seen", 3'b001);
    drive(1, 0, 0); chk("R3 fire b then a", 3'b111);
    drive(0, 0, 0); chk("R3 fire drops", 3'b011);
  endtask

  task automatic t_both();
    do_reset();
    drive(1, 1, 0); chk("R4 same-edge join", 3'b111);
    drive(0, 0, 0); chk("R4 pulse ends", 3'b011);
  endtask

  task automatic t_repeat();
    do_reset();
    drive(1, 0, 0); chk("R8 first a", 3'b010);
    drive(1, 0, 0); chk("R8 repeated a", 3'b010);
    drive(1, 0, 0); chk("R8 repeated a again", 3'b010);
    drive(0, 1, 0); chk("R8 b completes", 3'b111);
  endtask

  task automatic t_halt_ignore();
    do_reset();
    drive(1, 1, 0); chk("R5 join", 3'b111);
    drive(1, 0, 0); chk("R5 a ignored halted", 3'b011);
    drive(0, 1, 0); chk("R5 b ignored halted", 3'b011);
    drive(1, 1, 0); chk("R5 both ignored halted", 3'b011);
  endtask

  task automatic t_abort_mid();
    do_reset();
    drive(1, 0, 0); chk("R6 a before abort", 3'b010);
    drive(0, 0, 1); chk("R6 abort clears", 3'b000);
    drive(0, 1, 0); chk("R6 b after abort no fire", 3'b001);
    drive(1, 0, 0); chk("R6 new round fires", 3'b111);
  endtask

  task automatic t_abort_same();
    do_reset();
    drive(1, 0, 0); chk("R7 a seen", 3'b010);
    drive(0, 1, 1); chk("R7 abort beats b", 3'b000);
    drive(1, 1, 1); chk("R7 abort beats both", 3'b000);
    drive(0, 0, 0); chk("R7 stays quiet", 3'b000);
  endtask

  task automatic t_abort_halt();
    do_reset();
    drive(1, 1, 0); chk("R6 join", 3'b111);
    drive(0, 0, 0); chk("R6 halted", 3'b011);
    drive(0, 0, 1); chk("R6 abort from halt", 3'b000);
    drive(0, 1, 0); chk("R6 rearmed b", 3'b001);
    drive(1, 0, 0); chk("R6 refire after halt", 3'b111);
  endtask

  initial begin
    rst = 1'b1; ev_a = 1'b0; ev_b = 1'b0; abort_r = 1'b0;
    @(negedge clk);
    t_reset();
    t_a_then_b();
    t_b_then_a();
    t_both();
    t_repeat();
    t_halt_ignore();
    t_abort_mid();
    t_abort_same();
    t_abort_halt();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule